// File: doc/BRIEF.md
# Message Completion Queue Controller

This block manages a circular queue of message completion records that lives in external memory. The queue holds 2048 records of 8 bytes each (16 KB). Three offsets track it: a reserve offset advanced by a space allocator, a write offset advanced by each stored record, and a read offset advanced by each record handed back. Each offset is an 11-bit index with one extra wrap bit. Reset sets all three to zero.

A producer hands in a record on a valid/ready enqueue port. The block writes that record into memory at the address formed from the configured base and the write index. If the queue was empty, it also raises a one-cycle interrupt that names a target processor and an interrupt number. A consumer issues a dequeue request on a valid/ready port. The block answers with a one-cycle response that carries a hit flag. When the queue is empty the hit flag is 0 and nothing changes. Otherwise the record is read from memory at the read index and the read offset advances.

Back-pressure rules: a request is taken only in a cycle in which both valid and ready are high. Valid may stay high while ready is low, and the request fields must then be held. The response and interrupt pulses have no ready and cannot be stalled. Memory accesses run one at a time on a request/acknowledge port.

Top module: `mcq_ctrl`

## Requirements
- R1: After reset, all three offsets are zero and the queue is empty. `mem_req`, `irq_valid`, `rsp_valid` and `rsv_full` are low. With `cfg_en` high, `enq_ready` and `deq_ready` are high.
- R2: An accepted enqueue writes one 64-bit word to `mem_addr = {cfg_base, write index, 3'b000}`. The word carries status in bits [1:0], length-minus-one in [18:2], start offset in [37:19] and zeros above. The write offset advances by one on the acknowledge.
- R3: While `mem_req` is high and `mem_ack` is low, the next cycle keeps `mem_req` high with `mem_addr`, `mem_we` and `mem_wdata` unchanged. Only one access is outstanding at a time.
- R4: In the cycle after a write acknowledge, `irq_valid` pulses for one cycle exactly when the queue was empty as the enqueue was taken. The pulse carries `cfg_irq_cpu` (4 bits) and `cfg_irq_num` (6 bits).
- R5: A dequeue taken while the queue is empty gives `rsp_valid` in the next cycle with `rsp_hit`=0 and zero record fields. It makes no memory access and leaves the read offset unchanged.
- R6: A dequeue taken while the queue is not empty reads the word at `{cfg_base, read index, 3'b000}`. It gives `rsp_valid` with `rsp_hit`=1 and the unpacked record in the cycle after the acknowledge, then advances the read offset. Records come back in enqueue order.
- R7: The queue is full when the write and read indices are equal and their wrap bits differ. This happens after 2048 unread records. While the queue is full, `enq_ready` is low and no write takes place.
- R8: The indices wrap from 2047 to 0 and the wrap bit toggles, so storage and ordering continue correctly across the wrap.
- R9: When enqueue and dequeue requests are both valid in the same cycle and the enqueue can be taken, the enqueue wins and `deq_ready` is low.
- R10: Each cycle with `rsv_pulse` high advances the reserve offset. `rsv_full` is high when the reserve and read indices are equal and their wrap bits differ. A pulse while `rsv_full` is high is ignored.
- R11: While `cfg_en` is low, `enq_ready` and `deq_ready` are low and no request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Queue enable |
| cfg_base | input | 15 | Queue base (row/page bits) |
| cfg_irq_cpu | input | 4 | Processor to interrupt |
| cfg_irq_num | input | 6 | Interrupt number |
| enq_valid | input | 1 | Enqueue request valid |
| enq_ready | output | 1 | Enqueue request accepted when high with valid |
| enq_status | input | 2 | Record completion status (0 received, 1 aborted) |
| enq_len_m1 | input | 17 | Record length minus one, in 32-byte lines |
| enq_start | input | 19 | Record start offset |
| deq_valid | input | 1 | Dequeue request valid |
| deq_ready | output | 1 | Dequeue request accepted when high with valid |
| rsp_valid | output | 1 | Dequeue response pulse |
| rsp_hit | output | 1 | Response carries a record (queue was not empty) |
| rsp_status | output | 2 | Returned completion status |
| rsp_len_m1 | output | 17 | Returned length minus one |
| rsp_start | output | 19 | Returned start offset |
| rsv_pulse | input | 1 | Reserve one entry |
| rsv_full | output | 1 | Reserve offset is a full queue ahead of read |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 29 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory access done |
| mem_rdata | input | 64 | Memory read data, valid with ack |
| irq_valid | output | 1 | Interrupt pulse |
| irq_cpu | output | 4 | Interrupt target processor |
| irq_num | output | 6 | Interrupt number |

## Verification
A corrupted write or read offset shows at the memory port on the very next access, as a wrong index in `mem_addr`. It also shows within one dequeue as a record returned out of order or a wrong hit flag. A wrong empty test shows as a missing or extra interrupt pulse one cycle after the write acknowledge. A wrong full test shows only at the 2048th unread record, so the bench fills the queue completely and drains it across the index wrap. A reserve offset that moves when it should not shows as a full flag that fails to drop once the read offset advances by one.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  localparam int STAT_W      = 2;
  localparam int LEN_W       = 17;
  localparam int START_W     = 19;
  localparam int ENTRY_BYTES = 8;
  localparam int ENTRY_SH    = $clog2(ENTRY_BYTES);

  // status sits in the low bits of the stored word
  typedef struct packed {
    logic [START_W-1:0] start;
    logic [LEN_W-1:0]   len_m1;
    logic [STAT_W-1:0]  status;
  } mcq_rec_t;

  localparam int REC_W = $bits(mcq_rec_t);

  typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_READ} mcq_state_e;
endpackage

// File: rtl/mcq_offset.sv
module mcq_offset #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/mcq_cmp.sv
module mcq_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] lead,
  input  logic [W-1:0] trail,
  output logic         full,
  output logic         empty
);
  assign empty = (lead == trail);
  assign full  = (lead[W-2:0] == trail[W-2:0]) && (lead[W-1] != trail[W-1]);
endmodule

// File: rtl/mcq_seq.sv
module mcq_seq
  import mcq_pkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int BASE_W = 15,
  parameter int DATA_W = 64,
  localparam int AW    = BASE_W + IDX_W + ENTRY_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [3:0]        cfg_irq_cpu,
  input  logic [5:0]        cfg_irq_num,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  mcq_rec_t          enq_rec,
  input  logic              deq_valid,
  output logic              deq_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output mcq_rec_t          rsp_rec,
  input  logic [IDX_W:0]    wr_ofs,
  input  logic [IDX_W:0]    rd_ofs,
  input  logic              wr_full,
  input  logic              q_empty,
  output logic              wr_inc,
  output logic              rd_inc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq_valid,
  output logic [3:0]        irq_cpu,
  output logic [5:0]        irq_num
);
  mcq_state_e        state;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              was_empty_q;
  logic              enq_go, deq_go;
  logic              unused_rdata_hi;

  assign unused_rdata_hi = ^mem_rdata[DATA_W-1:REC_W];

  assign enq_ready = cfg_en && (state == SQ_IDLE) && !wr_full;
  assign enq_go    = enq_valid && enq_ready;
  assign deq_ready = cfg_en && (state == SQ_IDLE) && !enq_go;
  assign deq_go    = deq_valid && deq_ready;

  assign mem_req   = (state != SQ_IDLE);
  assign mem_we    = (state == SQ_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign wr_inc    = (state == SQ_WRITE) && mem_ack;
  assign rd_inc    = (state == SQ_READ) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      was_empty_q <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_rec     <= '0;
      irq_valid   <= 1'b0;
      irq_cpu     <= '0;
      irq_num     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      irq_valid <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (enq_go) begin
            state       <= SQ_WRITE;
            addr_q      <= {cfg_base, wr_ofs[IDX_W-1:0], ENTRY_SH'(0)};
            wdata_q     <= DATA_W'(enq_rec);
            was_empty_q <= q_empty;
          end else if (deq_go) begin
            if (q_empty) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b0;
              rsp_rec   <= '0;
            end else begin
              state  <= SQ_READ;
              addr_q <= {cfg_base, rd_ofs[IDX_W-1:0], ENTRY_SH'(0)};
            end
          end
        end
        SQ_WRITE: begin
          if (mem_ack) begin
            state     <= SQ_IDLE;
            irq_valid <= was_empty_q;
            irq_cpu   <= cfg_irq_cpu;
            irq_num   <= cfg_irq_num;
          end
        end
        SQ_READ: begin
          if (mem_ack) begin
            state     <= SQ_IDLE;
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_rec   <= mcq_rec_t'(mem_rdata[REC_W-1:0]);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcq_ctrl.sv
module mcq_ctrl
  import mcq_pkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int BASE_W = 15,
  parameter int DATA_W = 64,
  localparam int AW    = BASE_W + IDX_W + ENTRY_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [BASE_W-1:0]  cfg_base,
  input  logic [3:0]         cfg_irq_cpu,
  input  logic [5:0]         cfg_irq_num,
  input  logic               enq_valid,
  output logic               enq_ready,
  input  logic [STAT_W-1:0]  enq_status,
  input  logic [LEN_W-1:0]   enq_len_m1,
  input  logic [START_W-1:0] enq_start,
  input  logic               deq_valid,
  output logic               deq_ready,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [STAT_W-1:0]  rsp_status,
  output logic [LEN_W-1:0]   rsp_len_m1,
  output logic [START_W-1:0] rsp_start,
  input  logic               rsv_pulse,
  output logic               rsv_full,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               irq_valid,
  output logic [3:0]         irq_cpu,
  output logic [5:0]         irq_num
);
  localparam int OW = IDX_W + 1;
  localparam int NOFS = 3;
  localparam int O_RSV = 0, O_WR = 1, O_RD = 2;

  logic [NOFS-1:0] ofs_inc;
  logic [OW-1:0]   ofs [NOFS];
  logic            wr_full, q_empty, rsv_empty_unused;
  logic            wr_inc, rd_inc;
  mcq_rec_t        enq_rec, rsp_rec;

  assign enq_rec = '{start: enq_start, len_m1: enq_len_m1, status: enq_status};
  assign rsp_status = rsp_rec.status;
  assign rsp_len_m1 = rsp_rec.len_m1;
  assign rsp_start  = rsp_rec.start;

  assign ofs_inc[O_RSV] = rsv_pulse && !rsv_full;
  assign ofs_inc[O_WR]  = wr_inc;
  assign ofs_inc[O_RD]  = rd_inc;

  for (genvar g = 0; g < NOFS; g++) begin : g_ofs
    mcq_offset #(.W(OW)) u_ofs (
      .clk(clk), .rst_n(rst_n), .inc(ofs_inc[g]), .q(ofs[g])
    );
  end

  mcq_cmp #(.W(OW)) u_cmp_wr (
    .lead(ofs[O_WR]), .trail(ofs[O_RD]), .full(wr_full), .empty(q_empty)
  );
  mcq_cmp #(.W(OW)) u_cmp_rsv (
    .lead(ofs[O_RSV]), .trail(ofs[O_RD]), .full(rsv_full), .empty(rsv_empty_unused)
  );

  mcq_seq #(.IDX_W(IDX_W), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_irq_cpu(cfg_irq_cpu), .cfg_irq_num(cfg_irq_num),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_rec(enq_rec),
    .deq_valid(deq_valid), .deq_ready(deq_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rec(rsp_rec),
    .wr_ofs(ofs[O_WR]), .rd_ofs(ofs[O_RD]), .wr_full(wr_full), .q_empty(q_empty),
    .wr_inc(wr_inc), .rd_inc(rd_inc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq_valid(irq_valid), .irq_cpu(irq_cpu), .irq_num(irq_num)
  );
endmodule

// File: rtl/mcq_ctrl_sva.sv
module mcq_ctrl_sva #(
  parameter int AW = 29,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              enq_valid,
  input logic              enq_ready,
  input logic              deq_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              irq_valid
);
  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_irq_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(mem_req && mem_we && mem_ack));

  assert_miss_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !mem_req && $past(!mem_req));

  assert_hit_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(mem_req && !mem_we && mem_ack));

  assert_enq_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && enq_ready |-> !deq_ready);

  assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !enq_ready && !deq_ready);
endmodule

bind mcq_ctrl mcq_ctrl_sva #(.AW(AW), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .enq_valid(enq_valid),
  .enq_ready(enq_ready), .deq_ready(deq_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq_valid(irq_valid)
);

// File: tb/tb_mcq_ctrl.sv
module tb_mcq_ctrl;
  localparam int IDX_W = 11, BASE_W = 15, DATA_W = 64;
  localparam int DEPTH = 1 << IDX_W;
  localparam int AW = BASE_W + IDX_W + 3;
  localparam logic [BASE_W-1:0] BASE = 15'h5A3;

  logic clk = 0, rst_n = 0, cfg_en = 1;
  logic [BASE_W-1:0] cfg_base = BASE;
  logic [3:0] cfg_irq_cpu = 4'hB;
  logic [5:0] cfg_irq_num = 6'h2D;
  logic enq_valid = 0, deq_valid = 0, rsv_pulse = 0, mem_ack;
  logic [1:0] enq_status = 0;
  logic [16:0] enq_len_m1 = 0;
  logic [18:0] enq_start = 0;
  logic enq_ready, deq_ready, rsp_valid, rsp_hit, rsv_full, mem_req, mem_we, irq_valid;
  logic [1:0] rsp_status;
  logic [16:0] rsp_len_m1;
  logic [18:0] rsp_start;
  logic [AW-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [3:0] irq_cpu;
  logic [5:0] irq_num;

  always #2 clk = ~clk;

  mcq_ctrl dut (.*);

  // memory model: one-cycle acknowledge
  logic [DATA_W-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[IDX_W+2:3]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[IDX_W+2:3]];
    end else mem_ack <= 1'b0;
  end

  int total = 0, bad = 0;
  int irq_cnt = 0, rsp_cnt = 0, wr_cnt = 0, req_cyc = 0;
  logic [3:0] last_cpu; logic [5:0] last_num;
  logic last_hit; logic [37:0] last_rsp;
  logic [AW-1:0] last_waddr, last_raddr; logic [DATA_W-1:0] last_wdata;
  int rd_n = 0;
  logic [37:0] expq [$];

  always @(negedge clk) if (rst_n) begin
    if (irq_valid) begin irq_cnt++; last_cpu = irq_cpu; last_num = irq_num; end
    if (rsp_valid) begin rsp_cnt++; last_hit = rsp_hit; last_rsp = {rsp_start, rsp_len_m1, rsp_status}; end
    if (mem_req) req_cyc++;
    if (mem_req && mem_ack && mem_we) begin wr_cnt++; last_waddr = mem_addr; last_wdata = mem_wdata; end
    if (mem_req && mem_ack && !mem_we) last_raddr = mem_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [AW-1:0] addr_of(input int idx);
    return {BASE, IDX_W'(idx), 3'b000};
  endfunction

  task automatic do_enq(input logic [37:0] rec);
    @(negedge clk);
    {enq_start, enq_len_m1, enq_status} = rec;
    enq_valid = 1;
    #1; while (!enq_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); enq_valid = 0;
    repeat (3) @(negedge clk); #1;
    expq.push_back(rec);
  endtask

  task automatic do_deq();
    @(negedge clk); deq_valid = 1;
    #1; while (!deq_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); deq_valid = 0;
    repeat (3) @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk(enq_ready && deq_ready, "R1 readies", {enq_ready, deq_ready}, 2'b11);
    chk(!mem_req && !irq_valid && !rsp_valid && !rsv_full, "R1 outputs idle",
        {mem_req, irq_valid, rsp_valid, rsv_full}, 0);
  endtask

  task automatic t_empty_deq();
    int r0 = rsp_cnt, m0 = req_cyc;
    do_deq();
    chk(rsp_cnt == r0 + 1 && !last_hit, "R5 miss response", {rsp_cnt - r0, last_hit}, 2);
    chk(last_rsp == 0, "R5 miss record zero", last_rsp, 0);
    chk(req_cyc == m0, "R5 no memory access", req_cyc - m0, 0);
  endtask

  task automatic pop_check(input string req);
    logic [37:0] e = expq.pop_front();
    int r0 = rsp_cnt;
    do_deq();
    chk(rsp_cnt == r0 + 1 && last_hit && last_rsp == e, req, {last_hit, last_rsp}, {1'b1, e});
    chk(last_raddr == addr_of(rd_n), "R6 read address", last_raddr, addr_of(rd_n));
    rd_n++;
  endtask

  task automatic t_basic();
    int i0 = irq_cnt;
    logic [37:0] a = {19'h4_1234, 17'h1_0ABC, 2'd1};
    do_enq(a);
    chk(last_waddr == addr_of(0), "R2 write address", last_waddr, addr_of(0));
    chk(last_wdata == {26'b0, a}, "R2 write packing", last_wdata, {26'b0, a});
    chk(irq_cnt == i0 + 1 && last_cpu == 4'hB && last_num == 6'h2D, "R4 irq from empty",
        {irq_cnt - i0, last_cpu, last_num}, {1, 4'hB, 6'h2D});
    do_enq({19'h7_FFFF, 17'h0, 2'd0});
    chk(last_waddr == addr_of(1), "R2 write offset advanced", last_waddr, addr_of(1));
    chk(irq_cnt == i0 + 1, "R4 no irq when not empty", irq_cnt - i0, 1);
    pop_check("R6 first record");
    pop_check("R6 second record in order");
    t_empty_deq();
    do_enq({19'h1, 17'h1FFFF, 2'd3});
    chk(irq_cnt == i0 + 2, "R4 irq after drain", irq_cnt - i0, 2);
    pop_check("R6 record after refill");
  endtask

  task automatic t_full();
    int m0, i0 = irq_cnt, base = rd_n, errs = 0;
    for (int i = 0; i < DEPTH; i++) begin
      do_enq({19'(i * 7), 17'(i), 2'(i)});
      if (last_waddr != addr_of(base + i)) errs++;
    end
    chk(errs == 0, "R8 write index wraps", errs, 0);
    chk(irq_cnt == i0 + 1, "R4 one irq while filling", irq_cnt - i0, 1);
    @(negedge clk); #1;
    chk(!enq_ready, "R7 full blocks enqueue", enq_ready, 0);
    m0 = req_cyc;
    enq_valid = 1; repeat (4) @(negedge clk); enq_valid = 0; #1;
    chk(req_cyc == m0, "R7 no write when full", req_cyc - m0, 0);
    pop_check("R7 head after full");
    @(negedge clk); #1;
    chk(enq_ready, "R7 ready after one read", enq_ready, 1);
    errs = 0;
    for (int i = 1; i < DEPTH; i++) begin
      logic [37:0] e = expq.pop_front();
      do_deq();
      if (!last_hit || last_rsp != e) errs++;
      rd_n++;
    end
    chk(errs == 0, "R8 order kept across wrap", errs, 0);
    t_empty_deq();
  endtask

  task automatic t_tie();
    logic [37:0] a = {19'h3_3333, 17'h0_5555, 2'd2};
    int r0 = rsp_cnt;
    @(negedge clk);
    {enq_start, enq_len_m1, enq_status} = a;
    enq_valid = 1; deq_valid = 1; #1;
    chk(enq_ready && !deq_ready, "R9 enqueue wins tie", {enq_ready, deq_ready}, 2'b10);
    @(posedge clk); @(negedge clk); enq_valid = 0;
    #1; while (!deq_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); deq_valid = 0;
    repeat (3) @(negedge clk); #1;
    chk(rsp_cnt == r0 + 1 && last_hit && last_rsp == a, "R9 dequeue served after",
        {last_hit, last_rsp}, {1'b1, a});
    rd_n++;
  endtask

  task automatic t_reserve();
    int need = (rd_n + DEPTH) % (2 * DEPTH);
    @(negedge clk); rsv_pulse = 1;
    repeat (need - 1) @(negedge clk);
    #1; chk(!rsv_full, "R10 not full one short", rsv_full, 0);
    @(negedge clk); #1;
    chk(rsv_full, "R10 full after a queue of reserves", rsv_full, 1);
    @(negedge clk); rsv_pulse = 0; #1;
    chk(rsv_full, "R10 held full", rsv_full, 1);
    do_enq(38'h5);
    pop_check("R6 record during reserve test");
    chk(!rsv_full, "R10 extra pulse ignored", rsv_full, 0);
  endtask

  task automatic t_disable();
    int m0 = req_cyc, r0 = rsp_cnt;
    @(negedge clk); cfg_en = 0; enq_valid = 1; deq_valid = 1; #1;
    chk(!enq_ready && !deq_ready, "R11 readies low", {enq_ready, deq_ready}, 0);
    repeat (5) @(negedge clk);
    enq_valid = 0; deq_valid = 0; #1;
    chk(req_cyc == m0 && rsp_cnt == r0, "R11 nothing taken", {req_cyc - m0, rsp_cnt - r0}, 0);
    cfg_en = 1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_empty_deq();
    t_basic();
    t_full();
    t_tie();
    t_reserve();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule